// File: doc/BRIEF.md
# Multi-Phase Frame Sync Recovery

This block recovers framed serial data when the phase of the incoming bit stream is unknown relative to the local bit-rate clock. On every bit-clock cycle it receives a vector of four samples of the serial line. Each sample is taken at one of four evenly spaced phases of the clock, and bit position k of the vector holds phase lane k. Every lane has its own shifter and its own sync detector. All lanes watch the line in parallel for a zero bit followed by the fixed 16-bit sync header.

When one or more lanes complete the header on the same cycle, the block picks the lane at the middle of the matching group. That lane's sample point lies farthest from the bit transitions. The block locks onto that lane at once and takes the very next line bit as the first payload bit. Payload is packed into 16-bit words, most significant bit first, and each word comes with a one-cycle valid strobe. After a fixed number of words the block drops its lock and searches again. Each frame is therefore aligned from its own header alone, with no training sequence and no phase carried over from the previous frame.

The controller has two states. HUNT searches for the header. TRACK captures payload. The transition HUNT→TRACK (acquire) happens on any lane hit. The transition TRACK→HUNT (release) happens on the last bit of the last payload word. A synchronous reset forces HUNT from any state.

Top module: `frame_phase_sync`

## Requirements
- R1: A synchronous reset clears every lane shifter to zero and forces HUNT. On the cycle after reset, `frame_lock`, `word_valid`, `word_data` and `phase_sel` are all zero.
- R2: A lane hits when its 16 previous samples and its current sample, oldest first, equal a single 0 followed by `SYNC_WORD` sent MSB first. Reset-cleared shifter history counts as zeros.
- R3: The acquire happens on the clock edge at which the final header bit is presented. `frame_lock` is high from the next cycle. The first payload bit is the line sample of that next cycle.
- R4: The selected lane belongs to the lowest-indexed run of contiguous hitting lanes. If that run spans lanes lo..hi, the selected lane is lo + (hi-lo)/2, rounded down. The lane index is the bit position in `phase_samp`. With all four lanes hitting, lane 1 is selected. With lanes 1..3 hitting, lane 2. With lanes 0, 2 and 3 hitting, lane 0.
- R5: While locked, payload bits come only from the selected lane. Samples on the other lanes do not affect `word_data`.
- R6: Every 16 captured bits form one word, with the first captured bit in bit 15. `word_valid` is high for exactly one cycle, the cycle after the edge that captured the 16th bit, and `word_data` holds that word in that cycle.
- R7: After `FRAME_WORDS` words, `frame_lock` falls in the same cycle in which the last `word_valid` is high. The block returns to HUNT, and the next frame is acquired fresh, possibly on a different lane.
- R8: While locked, lane hits are ignored. A header pattern inside the payload neither restarts word counting nor changes `phase_sel`.
- R9: A header that is immediately preceded by a 1 on the line is not a hit, and the block stays in HUNT.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| phase_samp | input | PHASES | Line samples of this bit period, one per phase lane |
| word_data | output | WORD_W | Last assembled payload word |
| word_valid | output | 1 | One-cycle strobe marking a new word |
| frame_lock | output | 1 | High while a frame's payload is being captured |
| phase_sel | output | clog2(PHASES) | Lane chosen for the current frame |

## Verification
The assertions assume that the stimulus obeys the line rules. Every header is preceded by at least one 0 bit, and a lane whose sample point lies just after a bit edge reports either the new bit or the previous bit consistently within a frame. The bench builds each lane from one bit stream shifted by a phase offset, so lanes at or beyond the offset see the current bit and lanes before it see the previous bit. It can also invert whole lanes to imitate edge-corrupted phases. Every frame is preceded by a run of zeros, except in the deliberate case where a 1 comes directly before the header.

// File: rtl/fps_pkg.sv
`timescale 1ns/1ps
package fps_pkg;
    typedef enum logic [0:0] {
        ST_HUNT  = 1'b0,
        ST_TRACK = 1'b1
    } fps_state_e;
endpackage

// File: rtl/fps_lane.sv
`timescale 1ns/1ps
module fps_lane #(
    parameter int               WORD_W = 16,
    parameter logic [WORD_W-1:0] SYNC   = 16'hE25B
) (
    input  logic clk,
    input  logic rst,
    input  logic smp,
    output logic hit
);
    logic [WORD_W-1:0] hist;

    always_ff @(posedge clk) begin
        if (rst) hist <= '0;
        else     hist <= {hist[WORD_W-2:0], smp};
    end

    // oldest bit must be the guard zero, the rest the header ending with smp
    assign hit = ({hist, smp} == {1'b0, SYNC});
endmodule

// File: rtl/fps_pick.sv
`timescale 1ns/1ps
module fps_pick #(
    parameter int PHASES = 4,
    localparam int SEL_W = (PHASES > 1) ? $clog2(PHASES) : 1
) (
    input  logic [PHASES-1:0] hits,
    output logic [SEL_W-1:0]  pick,
    output logic              any
);
    always_comb begin
        int   lo;
        int   hi;
        logic found;
        logic run;
        lo    = 0;
        hi    = 0;
        found = 1'b0;
        run   = 1'b0;
        for (int i = 0; i < PHASES; i++) begin
            if (hits[i]) begin
                if (!found) begin
                    lo    = i;
                    hi    = i;
                    found = 1'b1;
                    run   = 1'b1;
                end else if (run) begin
                    hi = i;
                end
            end else if (found) begin
                run = 1'b0;
            end
        end
        pick = SEL_W'(lo + (hi - lo) / 2);
        any  = |hits;
    end
endmodule

// File: rtl/fps_asm.sv
`timescale 1ns/1ps
module fps_asm #(
    parameter int WORD_W      = 16,
    parameter int FRAME_WORDS = 4,
    localparam int BW = $clog2(WORD_W),
    localparam int CW = $clog2(FRAME_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              en,
    input  logic              bit_in,
    output logic [WORD_W-1:0] word,
    output logic              valid,
    output logic              frame_done
);
    logic [WORD_W-1:0] shreg;
    logic [BW-1:0]     bit_cnt;
    logic [CW-1:0]     word_cnt;
    logic              bit_last;

    assign bit_last   = (bit_cnt == BW'(WORD_W - 1));
    assign frame_done = en && bit_last && (word_cnt == CW'(FRAME_WORDS - 1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            shreg    <= '0;
            bit_cnt  <= '0;
            word_cnt <= '0;
        end else if (en) begin
            shreg   <= {shreg[WORD_W-2:0], bit_in};
            bit_cnt <= bit_last ? '0 : bit_cnt + 1'b1;
            if (bit_last) word_cnt <= word_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= en && bit_last;
            if (en && bit_last) word <= {shreg[WORD_W-2:0], bit_in};
        end
    end
endmodule

// File: rtl/frame_phase_sync.sv
`timescale 1ns/1ps
module frame_phase_sync
    import fps_pkg::*;
#(
    parameter int               PHASES      = 4,
    parameter int               WORD_W      = 16,
    parameter logic [WORD_W-1:0] SYNC_WORD   = 16'hE25B,
    parameter int               FRAME_WORDS = 4,
    localparam int SEL_W = (PHASES > 1) ? $clog2(PHASES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PHASES-1:0] phase_samp,
    output logic [WORD_W-1:0] word_data,
    output logic              word_valid,
    output logic              frame_lock,
    output logic [SEL_W-1:0]  phase_sel
);
    fps_state_e        state, state_nx;
    logic [PHASES-1:0] lane_hit;
    logic [SEL_W-1:0]  pick;
    logic              any_hit;
    logic              frame_done;

    genvar g;
    generate
        for (g = 0; g < PHASES; g++) begin : g_lane
            fps_lane #(.WORD_W(WORD_W), .SYNC(SYNC_WORD)) u_lane (
                .clk (clk),
                .rst (rst),
                .smp (phase_samp[g]),
                .hit (lane_hit[g])
            );
        end
    endgenerate

    fps_pick #(.PHASES(PHASES)) u_pick (
        .hits (lane_hit),
        .pick (pick),
        .any  (any_hit)
    );

    fps_asm #(.WORD_W(WORD_W), .FRAME_WORDS(FRAME_WORDS)) u_asm (
        .clk        (clk),
        .rst        (rst),
        .clear      (state == ST_HUNT),
        .en         (state == ST_TRACK),
        .bit_in     (phase_samp[phase_sel]),
        .word       (word_data),
        .valid      (word_valid),
        .frame_done (frame_done)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HUNT:  if (any_hit)    state_nx = ST_TRACK;   // acquire
            ST_TRACK: if (frame_done) state_nx = ST_HUNT;    // release
            default:                  state_nx = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_HUNT;
        else     state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_lock <= 1'b0;
            phase_sel  <= '0;
        end else begin
            frame_lock <= (state_nx == ST_TRACK);
            if (state == ST_HUNT && any_hit) phase_sel <= pick;
        end
    end
endmodule

module frame_phase_sync_chk #(
    parameter int PHASES = 4,
    parameter int WORD_W = 16,
    localparam int SEL_W = (PHASES > 1) ? $clog2(PHASES) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic [PHASES-1:0] lane_hit,
    input logic [WORD_W-1:0] word_data,
    input logic              word_valid,
    input logic              frame_lock,
    input logic [SEL_W-1:0]  phase_sel
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!frame_lock && !word_valid && word_data == '0));

    a_r3_lock_needs_hit: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_lock) |-> $past(|lane_hit));

    a_r4_sel_was_hit: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_lock) |-> (($past(lane_hit) & (PHASES'(1) << phase_sel)) != '0));

    a_r8_sel_held: assert property (@(posedge clk) disable iff (rst)
        (frame_lock && $past(frame_lock)) |-> $stable(phase_sel));

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> !word_valid);

    a_r6_valid_in_frame: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> $past(frame_lock));

    a_r7_drop_with_last: assert property (@(posedge clk) disable iff (rst)
        $fell(frame_lock) |-> word_valid);
endmodule

bind frame_phase_sync frame_phase_sync_chk #(.PHASES(PHASES), .WORD_W(WORD_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .lane_hit   (lane_hit),
    .word_data  (word_data),
    .word_valid (word_valid),
    .frame_lock (frame_lock),
    .phase_sel  (phase_sel)
);

// File: tb/frame_phase_sync_test.sv
`timescale 1ns/1ps
module frame_phase_sync_test;
    localparam int          PH = 4;
    localparam int          WW = 16;
    localparam int          FW = 4;
    localparam logic [15:0] SW = 16'hE25B;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [PH-1:0] samp = '0;
    logic [WW-1:0] word_data;
    logic          word_valid, frame_lock;
    logic [1:0]    phase_sel;

    always #2.5 clk = ~clk;

    frame_phase_sync #(.PHASES(PH), .WORD_W(WW), .SYNC_WORD(SW), .FRAME_WORDS(FW)) uut (
        .clk(clk), .rst(rst), .phase_samp(samp),
        .word_data(word_data), .word_valid(word_valid),
        .frame_lock(frame_lock), .phase_sel(phase_sel)
    );

    int total = 0, bad = 0, cycles = 0;

    // ---------------- behavioural reference model ----------------
    bit          hist[PH][$];
    bit          e_lock, e_valid;
    logic [15:0] e_word, m_acc;
    logic [1:0]  e_sel;
    int          m_bits, m_words;

    function automatic bit seen_header(int p);
        logic [16:0] v;
        for (int i = 0; i < 17; i++) v[16-i] = hist[p][i];
        return v == {1'b0, SW};
    endfunction

    always @(posedge clk) begin
        int first, len;
        if (rst) begin
            for (int p = 0; p < PH; p++) begin
                hist[p] = {};
                for (int i = 0; i < 17; i++) hist[p].push_back(1'b0);
            end
            e_lock = 0; e_valid = 0; e_word = '0; e_sel = '0;
            m_bits = 0; m_words = 0; m_acc = '0;
        end else begin
            e_valid = 0;
            for (int p = 0; p < PH; p++) begin
                hist[p].push_back(samp[p]);
                void'(hist[p].pop_front());
            end
            if (e_lock) begin
                m_acc = {m_acc[14:0], samp[e_sel]};
                m_bits++;
                if (m_bits == 16) begin
                    m_bits = 0; e_word = m_acc; e_valid = 1; m_words++;
                    if (m_words == FW) e_lock = 0;
                end
            end else begin
                first = -1; len = 0;
                for (int p = 0; p < PH; p++)
                    if (seen_header(p)) begin
                        if (first < 0) begin first = p; len = 1; end
                        else if (p == first + len) len++;
                    end
                if (first >= 0) begin
                    e_lock = 1; e_sel = 2'(first + (len - 1) / 2);
                    m_bits = 0; m_words = 0;
                end
            end
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    int  lock_rises, words_seen;
    bit  prev_lock;
    logic [1:0] lock_sel;

    task automatic clr();
        lock_rises = 0; words_seen = 0;
    endtask

    task automatic step(input logic [PH-1:0] v);
        @(negedge clk);
        chk(frame_lock === e_lock, "R3 frame_lock", 32'(frame_lock), 32'(e_lock));
        if (e_lock && frame_lock)
            chk(phase_sel === e_sel, "R4 phase_sel", 32'(phase_sel), 32'(e_sel));
        chk(word_valid === e_valid, "R6 word_valid", 32'(word_valid), 32'(e_valid));
        if (e_valid)
            chk(word_data === e_word, "R5 word_data", 32'(word_data), 32'(e_word));
        if (frame_lock && !prev_lock) begin lock_rises++; lock_sel = phase_sel; end
        prev_lock = frame_lock;
        if (word_valid) words_seen++;
        samp = v;
    endtask

    // ---------------- stimulus ----------------
    bit tx[$];

    task automatic push_word(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) tx.push_back(w[i]);
    endtask

    task automatic add_frame(input int gap, input int kind);
        for (int i = 0; i < gap; i++) tx.push_back(1'b0);
        push_word(SW);
        for (int k = 0; k < FW; k++) begin
            if (kind == 1 && k == 0)      push_word(16'h0000);
            else if (kind == 1 && k == 1) push_word(SW);
            else                          push_word(16'($urandom));
        end
    endtask

    task automatic play(input int off, input logic [PH-1:0] inv, input int cut);
        int n, ncyc;
        n = tx.size();
        ncyc = (cut > 0) ? cut : n + 2;
        for (int c = 0; c < ncyc; c++) begin
            logic [PH-1:0] v;
            for (int p = 0; p < PH; p++) begin
                int idx;
                idx  = 4 * c + p - off;
                v[p] = ((idx < 0 || idx / 4 >= n) ? 1'b0 : tx[idx / 4]) ^ inv[p];
            end
            step(v);
        end
        tx = {};
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step('0); step('0);
        chk(frame_lock === 1'b0 && word_valid === 1'b0 && word_data === '0 && phase_sel === '0,
            "R1 reset state", {frame_lock, word_valid, 14'd0, word_data}, 32'd0);
        rst = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=finish", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int exp_sel[4];
        exp_sel = '{1, 2, 2, 3};
        do_reset();

        // each phase offset, consecutive frames without reset (R2, R4, R7)
        for (int off = 0; off < 4; off++) begin
            clr();
            add_frame(3, 0);
            play(off, '0, 0);
            chk(lock_rises == 1, "R2 header acquired", lock_rises, 1);
            chk(lock_sel == 2'(exp_sel[off]), "R4 middle lane", 32'(lock_sel), exp_sel[off]);
            chk(words_seen == FW, "R7 words per frame", words_seen, FW);
        end

        // corrupted lanes shape the matching group (R4, R5)
        clr(); add_frame(2, 0); play(0, 4'b0010, 0);
        chk(lock_sel == 2'd0, "R4 first run only", 32'(lock_sel), 0);
        clr(); add_frame(2, 0); play(0, 4'b1000, 0);
        chk(lock_sel == 2'd1, "R4 run 0..2", 32'(lock_sel), 1);
        clr(); add_frame(2, 0); play(0, 4'b0001, 0);
        chk(lock_sel == 2'd2, "R4 run 1..3 R5 other lane", 32'(lock_sel), 2);

        // header inside payload is ignored (R8)
        clr(); add_frame(2, 1); play(1, '0, 0);
        chk(lock_rises == 1, "R8 no relock", lock_rises, 1);
        chk(words_seen == FW, "R8 word count", words_seen, FW);

        // back-to-back frames with one zero gap, new phase (R7)
        clr(); add_frame(1, 0); add_frame(1, 0); play(3, '0, 0);
        chk(lock_rises == 2, "R7 fresh reacquire", lock_rises, 2);
        chk(words_seen == 2 * FW, "R7 two frames", words_seen, 2 * FW);

        // header preceded by a one (R9)
        do_reset();
        clr();
        tx.push_back(1'b1); push_word(SW);
        for (int i = 0; i < 40; i++) tx.push_back(1'b1);
        play(0, '0, 0);
        chk(lock_rises == 0, "R9 no lock after one", lock_rises, 0);

        // reset in mid-frame (R1)
        do_reset();
        clr(); add_frame(2, 0); play(2, '0, 30);
        chk(frame_lock === 1'b1, "R3 locked mid-frame", 32'(frame_lock), 1);
        do_reset();
        step('0);
        chk(frame_lock === 1'b0, "R1 reset drops lock", 32'(frame_lock), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule